// File: doc/BRIEF.md
# Armed Endpoint Buffer Manager

This block sits between a USB protocol engine and a processor and lets both share packet data through two on-chip memories. The processor fills the transmit memory and reads the receive memory. The protocol engine reads the transmit memory for device-to-host (IN) transfers and fills the receive memory for host-to-device (OUT) transfers. Each endpoint direction, called a slot, keeps a buffer pointer, a byte length, and four state bits: armed, data toggle, stall and pending.

Software prepares a slot and sets its armed bit. When the engine presents a token, the block answers with a handshake code. On an accepted IN token it streams the slot's bytes out of the transmit memory. On an accepted OUT token it writes the incoming bytes into the receive memory. When the transfer finishes, the block moves the pointer, records the length and marks the slot pending. Further tokens for that slot get NAK until software clears the pending bit. Framing, CRC and the handshake sent back from the host are handled outside this block.

Top module: `epbuf_mgr`

## Requirements
- R1: After synchronous reset, the armed, toggle, stall and pending masks are all zero and every length is zero. The pointer of OUT slot n is n*(DEPTH/NUM_EP) and every IN pointer is zero. No response and no transmit byte is produced.
- R2: Slot index s = 2n + d, with d = 0 for OUT and d = 1 for IN. Bit s of every mask port belongs to slot s. The readback selector uses the same index.
- R3: `resp_valid` is high exactly one cycle after a token cycle. `resp_code` is 0 for ACK, 1 for NAK and 2 for STALL. `resp_tog` carries the slot's stored toggle bit.
- R4: The answer to a token is chosen in this priority order: a stalled slot answers STALL, then a pending slot answers NAK, then an armed slot answers ACK. A slot that is none of these answers NAK.
- R5: An accepted IN token makes the block send the slot's length in bytes on `tx_data`, one per cycle. The bytes are read from the transmit memory starting at the slot pointer, and addresses wrap modulo DEPTH. `tx_last` marks the final byte. A length of zero sends no bytes.
- R6: After an accepted OUT token, each `rx_valid` byte is written to the receive memory at the slot pointer, and the pointer steps by one after every byte. A cycle with `rx_end` high closes the packet.
- R7: When a transfer completes, the slot becomes pending, its armed bit clears and its toggle inverts. For IN, the pointer advances by the length and the length becomes 0. For OUT, the pointer advances by the received count and the length becomes that count. If software writes the slot in the same cycle, the completion takes effect and the software write is lost.
- R8: After a NAK or STALL answer, no byte is sent, `rx` bytes are not written, and no slot state changes.
- R9: Software controls the slots through these writes. `cpu_arm_set` sets armed bits. `cpu_pend_clr` clears pending bits. The toggle and stall masks are written whole. `cpu_in_we` loads the pointer and length of IN slot `cpu_in_ep`.
- R10: A token for an endpoint number at or above NUM_EP is answered NAK with toggle 0 and changes nothing.
- R11: Software writes the transmit memory. Software reads the receive memory with one cycle of latency. Slot pointer and length readback also has one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_obuf_we | input | 1 | Transmit memory write strobe |
| cpu_obuf_addr | input | AW | Transmit memory write address |
| cpu_obuf_wdata | input | DW | Transmit memory write data |
| cpu_ibuf_addr | input | AW | Receive memory read address |
| cpu_ibuf_rdata | output | DW | Receive memory read data, one cycle later |
| cpu_arm_set | input | 2*NUM_EP | Pulse mask that sets armed bits |
| cpu_pend_clr | input | 2*NUM_EP | Pulse mask that clears pending bits |
| cpu_tog_we | input | 1 | Toggle mask write strobe |
| cpu_tog_wdata | input | 2*NUM_EP | New toggle mask |
| cpu_stall_we | input | 1 | Stall mask write strobe |
| cpu_stall_wdata | input | 2*NUM_EP | New stall mask |
| cpu_in_we | input | 1 | IN slot pointer and length write strobe |
| cpu_in_ep | input | EPW | Endpoint number for the IN slot write |
| cpu_in_ptr | input | AW | New IN pointer |
| cpu_in_len | input | AW+1 | New IN length |
| cpu_rd_slot | input | EPW+1 | Slot selected for readback |
| cpu_rd_ptr | output | AW | Pointer of the selected slot |
| cpu_rd_len | output | AW+1 | Length of the selected slot |
| arm_mask | output | 2*NUM_EP | Armed bits |
| tog_mask | output | 2*NUM_EP | Toggle bits |
| stall_mask | output | 2*NUM_EP | Stall bits |
| pend_mask | output | 2*NUM_EP | Pending bits |
| tok_valid | input | 1 | Token strobe from the protocol engine |
| tok_ep | input | EPW | Token endpoint number |
| tok_dir | input | 1 | Token direction, 1 = IN |
| resp_valid | output | 1 | Handshake answer strobe |
| resp_code | output | 2 | Handshake code |
| resp_tog | output | 1 | Data toggle for the transfer |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | DW | Transmit byte |
| tx_last | output | 1 | Final transmit byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | DW | Received byte |
| rx_end | input | 1 | End of received packet |

## Verification
A stale pending or armed bit shows up in the very next handshake answer: the port reports ACK where NAK is due, or the reverse. A wrong toggle shows up one cycle after the token on `resp_tog`. A bad pointer or length shows in the transmitted byte stream as soon as the first byte leaves, or on slot readback a few cycles after completion. Bytes written to the receive memory after a refused token stay hidden until software reads that address, so the bench reads those locations back directly.

// File: rtl/epbuf_pkg.sv
package epbuf_pkg;
  typedef enum logic [1:0] {
    RESP_ACK   = 2'd0,
    RESP_NAK   = 2'd1,
    RESP_STALL = 2'd2
  } resp_e;

  typedef enum logic [1:0] {
    XS_IDLE,
    XS_SEND,
    XS_RECV,
    XS_FIN
  } xfer_st_e;
endpackage

// File: rtl/epbuf_ram.sv
module epbuf_ram #(
  parameter int AW = 9,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // Power-up contents, kept as an FPGA initialisation image.
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/epbuf_ctl.sv
module epbuf_ctl #(
  parameter int NUM_EP = 3,
  parameter int AW     = 9,
  localparam int LW     = AW + 1,
  localparam int EPW    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int SW     = EPW + 1,
  localparam int SLOTS  = 2 * NUM_EP,
  localparam int REGION = (1 << AW) / NUM_EP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SLOTS-1:0] cpu_arm_set,
  input  logic [SLOTS-1:0] cpu_pend_clr,
  input  logic             cpu_tog_we,
  input  logic [SLOTS-1:0] cpu_tog_wdata,
  input  logic             cpu_stall_we,
  input  logic [SLOTS-1:0] cpu_stall_wdata,
  input  logic             cpu_in_we,
  input  logic [EPW-1:0]   cpu_in_ep,
  input  logic [AW-1:0]    cpu_in_ptr,
  input  logic [LW-1:0]    cpu_in_len,
  input  logic [SW-1:0]    cpu_rd_slot,
  output logic [AW-1:0]    cpu_rd_ptr,
  output logic [LW-1:0]    cpu_rd_len,
  input  logic             done_valid,
  input  logic [SW-1:0]    done_slot,
  input  logic [AW-1:0]    done_ptr,
  input  logic [LW-1:0]    done_len,
  input  logic [SW-1:0]    q_slot,
  output logic [AW-1:0]    q_ptr,
  output logic [LW-1:0]    q_len,
  output logic [SLOTS-1:0] arm,
  output logic [SLOTS-1:0] tog,
  output logic [SLOTS-1:0] stall,
  output logic [SLOTS-1:0] pend
);
  logic [AW-1:0] ptr_arr [SLOTS];
  logic [LW-1:0] len_arr [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int PRST = (s % 2 == 0) ? (s / 2) * REGION : 0;
    logic          arm_q, tog_q, stall_q, pend_q;
    logic [AW-1:0] ptr_q;
    logic [LW-1:0] len_q;
    logic          hit, in_wr;

    assign hit   = done_valid && (done_slot == SW'(s));
    assign in_wr = cpu_in_we && (s % 2 == 1) && (cpu_in_ep == EPW'(s / 2));

    always_ff @(posedge clk) begin
      if (rst) begin
        arm_q   <= 1'b0;
        tog_q   <= 1'b0;
        stall_q <= 1'b0;
        pend_q  <= 1'b0;
        ptr_q   <= AW'(PRST);
        len_q   <= '0;
      end else begin
        if (hit) begin
          // completion overrides any software write to this slot
          pend_q <= 1'b1;
          arm_q  <= 1'b0;
          tog_q  <= ~tog_q;
          ptr_q  <= done_ptr;
          len_q  <= done_len;
        end else begin
          if (cpu_arm_set[s])  arm_q  <= 1'b1;
          if (cpu_pend_clr[s]) pend_q <= 1'b0;
          if (cpu_tog_we)      tog_q  <= cpu_tog_wdata[s];
          if (in_wr) begin
            ptr_q <= cpu_in_ptr;
            len_q <= cpu_in_len;
          end
        end
        if (cpu_stall_we) stall_q <= cpu_stall_wdata[s];
      end
    end

    assign arm[s]     = arm_q;
    assign tog[s]     = tog_q;
    assign stall[s]   = stall_q;
    assign pend[s]    = pend_q;
    assign ptr_arr[s] = ptr_q;
    assign len_arr[s] = len_q;
  end

  assign q_ptr = ptr_arr[q_slot];
  assign q_len = len_arr[q_slot];

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rd_ptr <= '0;
      cpu_rd_len <= '0;
    end else begin
      cpu_rd_ptr <= ptr_arr[cpu_rd_slot];
      cpu_rd_len <= len_arr[cpu_rd_slot];
    end
  end

  // R7: completion marks the slot pending
  a_r7_done_sets_pend: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> pend[$past(done_slot)]);

  // R7: completion disarms the slot
  a_r7_done_clears_arm: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !arm[$past(done_slot)]);

  // R7: completion inverts the toggle
  a_r7_done_flips_tog: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> tog[$past(done_slot)] != $past(tog[done_slot]));

  // R9: a pending clear without a completion leaves the bits cleared
  a_r9_pend_clear: assert property (@(posedge clk) disable iff (rst)
    (!done_valid && (|cpu_pend_clr)) |=> ((pend & $past(cpu_pend_clr)) == '0));
endmodule

// File: rtl/epbuf_xfer.sv
module epbuf_xfer
  import epbuf_pkg::*;
#(
  parameter int NUM_EP = 3,
  parameter int AW     = 9,
  parameter int DW     = 8,
  localparam int LW    = AW + 1,
  localparam int EPW   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int SW    = EPW + 1,
  localparam int SLOTS = 2 * NUM_EP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tok_valid,
  input  logic [EPW-1:0]   tok_ep,
  input  logic             tok_dir,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_data,
  input  logic             rx_end,
  input  logic [SLOTS-1:0] arm,
  input  logic [SLOTS-1:0] tog,
  input  logic [SLOTS-1:0] stall,
  input  logic [SLOTS-1:0] pend,
  output logic [SW-1:0]    q_slot,
  input  logic [AW-1:0]    q_ptr,
  input  logic [LW-1:0]    q_len,
  output logic             resp_valid,
  output logic [1:0]       resp_code,
  output logic             resp_tog,
  output logic [AW-1:0]    obuf_raddr,
  output logic             tx_valid,
  output logic             tx_last,
  output logic             ibuf_we,
  output logic [AW-1:0]    ibuf_waddr,
  output logic [DW-1:0]    ibuf_wdata,
  output logic             done_valid,
  output logic [SW-1:0]    done_slot,
  output logic [AW-1:0]    done_ptr,
  output logic [LW-1:0]    done_len
);
  xfer_st_e      st;
  resp_e         code, resp_q;
  logic [SW-1:0] slot;
  logic          in_range, tog_pick, rd_issue;
  logic [AW-1:0] cur;
  logic [LW-1:0] rem, cnt;

  assign slot     = {tok_ep, tok_dir};
  assign q_slot   = slot;
  assign in_range = 32'(tok_ep) < NUM_EP;
  assign tog_pick = in_range ? tog[slot] : 1'b0;

  always_comb begin
    code = RESP_NAK;
    if (in_range) begin
      if (stall[slot])     code = RESP_STALL;
      else if (pend[slot]) code = RESP_NAK;
      else if (arm[slot])  code = RESP_ACK;
    end
  end

  assign rd_issue   = (st == XS_SEND) && (rem != '0);
  assign obuf_raddr = cur;
  assign ibuf_we    = (st == XS_RECV) && rx_valid && !rx_end;
  assign ibuf_waddr = cur;
  assign ibuf_wdata = rx_data;
  assign resp_code  = resp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= XS_IDLE;
      resp_valid <= 1'b0;
      resp_q     <= RESP_NAK;
      resp_tog   <= 1'b0;
      cur        <= '0;
      rem        <= '0;
      cnt        <= '0;
      done_valid <= 1'b0;
      done_slot  <= '0;
      done_ptr   <= '0;
      done_len   <= '0;
      tx_valid   <= 1'b0;
      tx_last    <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      done_valid <= 1'b0;
      tx_valid   <= rd_issue;
      tx_last    <= rd_issue && (rem == LW'(1));
      unique case (st)
        XS_IDLE: if (tok_valid) begin
          resp_valid <= 1'b1;
          resp_q     <= code;
          resp_tog   <= tog_pick;
          done_slot  <= slot;
          if (code == RESP_ACK) begin
            cur <= q_ptr;
            rem <= tok_dir ? q_len : '0;
            cnt <= '0;
            st  <= tok_dir ? XS_SEND : XS_RECV;
          end
        end
        XS_SEND: begin
          if (rem != '0) begin
            cur <= cur + 1'b1;
            rem <= rem - 1'b1;
          end else begin
            done_valid <= 1'b1;
            done_ptr   <= cur;
            done_len   <= '0;
            st         <= XS_FIN;
          end
        end
        XS_RECV: begin
          if (rx_end) begin
            done_valid <= 1'b1;
            done_ptr   <= cur;
            done_len   <= cnt;
            st         <= XS_FIN;
          end else if (rx_valid) begin
            cur <= cur + 1'b1;
            cnt <= cnt + 1'b1;
          end
        end
        XS_FIN: st <= XS_IDLE;
        default: st <= XS_IDLE;
      endcase
    end
  end

  // R4: stall outranks everything
  a_r4_stall_first: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && st == XS_IDLE && in_range && stall[slot])
      |=> (resp_valid && resp_code == RESP_STALL));

  // R4: a pending slot is refused even when armed
  a_r4_pending_nak: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && st == XS_IDLE && in_range && !stall[slot] && pend[slot])
      |=> (resp_valid && resp_code == RESP_NAK));

  // R10: unknown endpoint gets NAK with toggle 0
  a_r10_range_nak: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && st == XS_IDLE && !in_range)
      |=> (resp_valid && resp_code == RESP_NAK && !resp_tog));

  // R8: a refused token starts no transfer
  a_r8_refused_idle: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_code != RESP_ACK) |-> (st == XS_IDLE));
endmodule

// File: rtl/epbuf_mgr.sv
module epbuf_mgr #(
  parameter int NUM_EP = 3,
  parameter int DEPTH  = 512,
  parameter int DW     = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1,
  localparam int EPW   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int SW    = EPW + 1,
  localparam int SLOTS = 2 * NUM_EP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_obuf_we,
  input  logic [AW-1:0]    cpu_obuf_addr,
  input  logic [DW-1:0]    cpu_obuf_wdata,
  input  logic [AW-1:0]    cpu_ibuf_addr,
  output logic [DW-1:0]    cpu_ibuf_rdata,
  input  logic [SLOTS-1:0] cpu_arm_set,
  input  logic [SLOTS-1:0] cpu_pend_clr,
  input  logic             cpu_tog_we,
  input  logic [SLOTS-1:0] cpu_tog_wdata,
  input  logic             cpu_stall_we,
  input  logic [SLOTS-1:0] cpu_stall_wdata,
  input  logic             cpu_in_we,
  input  logic [EPW-1:0]   cpu_in_ep,
  input  logic [AW-1:0]    cpu_in_ptr,
  input  logic [LW-1:0]    cpu_in_len,
  input  logic [SW-1:0]    cpu_rd_slot,
  output logic [AW-1:0]    cpu_rd_ptr,
  output logic [LW-1:0]    cpu_rd_len,
  output logic [SLOTS-1:0] arm_mask,
  output logic [SLOTS-1:0] tog_mask,
  output logic [SLOTS-1:0] stall_mask,
  output logic [SLOTS-1:0] pend_mask,
  input  logic             tok_valid,
  input  logic [EPW-1:0]   tok_ep,
  input  logic             tok_dir,
  output logic             resp_valid,
  output logic [1:0]       resp_code,
  output logic             resp_tog,
  output logic             tx_valid,
  output logic [DW-1:0]    tx_data,
  output logic             tx_last,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_data,
  input  logic             rx_end
);
  logic [SW-1:0] q_slot, done_slot;
  logic [AW-1:0] q_ptr, done_ptr, obuf_raddr, ibuf_waddr;
  logic [LW-1:0] q_len, done_len;
  logic          done_valid, ibuf_we;
  logic [DW-1:0] ibuf_wdata;

  epbuf_ram #(.AW(AW), .DW(DW)) i_obuf (
    .clk(clk), .we(cpu_obuf_we), .waddr(cpu_obuf_addr), .wdata(cpu_obuf_wdata),
    .raddr(obuf_raddr), .rdata(tx_data));

  epbuf_ram #(.AW(AW), .DW(DW)) i_ibuf (
    .clk(clk), .we(ibuf_we), .waddr(ibuf_waddr), .wdata(ibuf_wdata),
    .raddr(cpu_ibuf_addr), .rdata(cpu_ibuf_rdata));

  epbuf_ctl #(.NUM_EP(NUM_EP), .AW(AW)) i_ctl (
    .clk(clk), .rst(rst),
    .cpu_arm_set(cpu_arm_set), .cpu_pend_clr(cpu_pend_clr),
    .cpu_tog_we(cpu_tog_we), .cpu_tog_wdata(cpu_tog_wdata),
    .cpu_stall_we(cpu_stall_we), .cpu_stall_wdata(cpu_stall_wdata),
    .cpu_in_we(cpu_in_we), .cpu_in_ep(cpu_in_ep),
    .cpu_in_ptr(cpu_in_ptr), .cpu_in_len(cpu_in_len),
    .cpu_rd_slot(cpu_rd_slot), .cpu_rd_ptr(cpu_rd_ptr), .cpu_rd_len(cpu_rd_len),
    .done_valid(done_valid), .done_slot(done_slot),
    .done_ptr(done_ptr), .done_len(done_len),
    .q_slot(q_slot), .q_ptr(q_ptr), .q_len(q_len),
    .arm(arm_mask), .tog(tog_mask), .stall(stall_mask), .pend(pend_mask));

  epbuf_xfer #(.NUM_EP(NUM_EP), .AW(AW), .DW(DW)) i_xfer (
    .clk(clk), .rst(rst),
    .tok_valid(tok_valid), .tok_ep(tok_ep), .tok_dir(tok_dir),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end),
    .arm(arm_mask), .tog(tog_mask), .stall(stall_mask), .pend(pend_mask),
    .q_slot(q_slot), .q_ptr(q_ptr), .q_len(q_len),
    .resp_valid(resp_valid), .resp_code(resp_code), .resp_tog(resp_tog),
    .obuf_raddr(obuf_raddr), .tx_valid(tx_valid), .tx_last(tx_last),
    .ibuf_we(ibuf_we), .ibuf_waddr(ibuf_waddr), .ibuf_wdata(ibuf_wdata),
    .done_valid(done_valid), .done_slot(done_slot),
    .done_ptr(done_ptr), .done_len(done_len));

  // R3: a response follows only a token accepted in the previous cycle
  a_r3_resp_after_tok: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(tok_valid));
endmodule

// File: tb/test_epbuf_mgr.sv
module test_epbuf_mgr;
  localparam int NUM_EP = 3, DEPTH = 512, DW = 8;
  localparam int AW = 9, LW = 10, EPW = 2, SW = 3, SLOTS = 6;
  localparam logic [1:0] C_ACK = 2'd0, C_NAK = 2'd1, C_STALL = 2'd2;

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_obuf_we = 0; logic [AW-1:0] cpu_obuf_addr = '0; logic [DW-1:0] cpu_obuf_wdata = '0;
  logic [AW-1:0] cpu_ibuf_addr = '0; logic [DW-1:0] cpu_ibuf_rdata;
  logic [SLOTS-1:0] cpu_arm_set = '0, cpu_pend_clr = '0, cpu_tog_wdata = '0, cpu_stall_wdata = '0;
  logic cpu_tog_we = 0, cpu_stall_we = 0, cpu_in_we = 0;
  logic [EPW-1:0] cpu_in_ep = '0; logic [AW-1:0] cpu_in_ptr = '0; logic [LW-1:0] cpu_in_len = '0;
  logic [SW-1:0] cpu_rd_slot = '0; logic [AW-1:0] cpu_rd_ptr; logic [LW-1:0] cpu_rd_len;
  logic [SLOTS-1:0] arm_mask, tog_mask, stall_mask, pend_mask;
  logic tok_valid = 0; logic [EPW-1:0] tok_ep = '0; logic tok_dir = 0;
  logic resp_valid, resp_tog, tx_valid, tx_last;
  logic [1:0] resp_code; logic [DW-1:0] tx_data;
  logic rx_valid = 0, rx_end = 0; logic [DW-1:0] rx_data = '0;

  always #2 clk = ~clk;

  epbuf_mgr #(.NUM_EP(NUM_EP), .DEPTH(DEPTH), .DW(DW)) i_epbuf_mgr (.*);

  int n_chk = 0, n_fail = 0;
  logic [1:0] q_code[$]; logic q_tog[$]; string q_tag[$];
  logic [DW-1:0] q_txd[$]; logic q_txl[$];

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as the design produces results
  initial forever begin
    @(negedge clk);
    if (!rst) begin
      if (resp_valid) begin
        if (q_code.size() == 0) check("R3", "unexpected response", 1, 0);
        else begin
          string t = q_tag.pop_front();
          check(t, "resp_code", 32'(resp_code), 32'(q_code.pop_front()));
          check(t, "resp_tog", 32'(resp_tog), 32'(q_tog.pop_front()));
        end
      end
      if (tx_valid) begin
        if (q_txd.size() == 0) check("R8", "unexpected tx byte", 1, 0);
        else begin
          check("R5", "tx_data", 32'(tx_data), 32'(q_txd.pop_front()));
          check("R5", "tx_last", 32'(tx_last), 32'(q_txl.pop_front()));
        end
      end
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic obuf_wr(int a, int d);
    @(negedge clk); cpu_obuf_we = 1; cpu_obuf_addr = AW'(a); cpu_obuf_wdata = DW'(d);
    @(negedge clk); cpu_obuf_we = 0;
  endtask
  task automatic arm_set(logic [SLOTS-1:0] m);
    @(negedge clk); cpu_arm_set = m; @(negedge clk); cpu_arm_set = '0;
  endtask
  task automatic pend_clr(logic [SLOTS-1:0] m);
    @(negedge clk); cpu_pend_clr = m; @(negedge clk); cpu_pend_clr = '0;
  endtask
  task automatic tog_wr(logic [SLOTS-1:0] m);
    @(negedge clk); cpu_tog_we = 1; cpu_tog_wdata = m; @(negedge clk); cpu_tog_we = 0;
  endtask
  task automatic stall_wr(logic [SLOTS-1:0] m);
    @(negedge clk); cpu_stall_we = 1; cpu_stall_wdata = m; @(negedge clk); cpu_stall_we = 0;
  endtask
  task automatic in_set(int ep, int p, int l);
    @(negedge clk); cpu_in_we = 1; cpu_in_ep = EPW'(ep); cpu_in_ptr = AW'(p); cpu_in_len = LW'(l);
    @(negedge clk); cpu_in_we = 0;
  endtask
  task automatic rd_ibuf(int a, output logic [DW-1:0] v);
    @(negedge clk); cpu_ibuf_addr = AW'(a); @(negedge clk); v = cpu_ibuf_rdata;
  endtask
  task automatic rd_slot(int s, output logic [AW-1:0] p, output logic [LW-1:0] l);
    @(negedge clk); cpu_rd_slot = SW'(s); @(negedge clk); p = cpu_rd_ptr; l = cpu_rd_len;
  endtask
  // driver: pushes the expected answer, then presents the token
  task automatic token(int ep, bit dir, logic [1:0] code, bit tg, string tag);
    q_code.push_back(code); q_tog.push_back(tg); q_tag.push_back(tag);
    @(negedge clk); tok_valid = 1; tok_ep = EPW'(ep); tok_dir = dir;
    @(negedge clk); tok_valid = 0;
  endtask
  task automatic exp_tx(int d, bit last); q_txd.push_back(DW'(d)); q_txl.push_back(last); endtask
  task automatic rx_byte(int d);
    @(negedge clk); rx_valid = 1; rx_data = DW'(d); @(negedge clk); rx_valid = 0;
  endtask
  task automatic rx_close; @(negedge clk); rx_end = 1; @(negedge clk); rx_end = 0; endtask

  initial begin
    #400000;
    check("WD", "watchdog expired", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] p; logic [LW-1:0] l; logic [DW-1:0] v;
    cyc(5); rst = 0; cyc(1);
    // R1 reset state
    check("R1", "arm", 32'(arm_mask), 0); check("R1", "tog", 32'(tog_mask), 0);
    check("R1", "stall", 32'(stall_mask), 0); check("R1", "pend", 32'(pend_mask), 0);
    check("R1", "resp_valid", 32'(resp_valid), 0); check("R1", "tx_valid", 32'(tx_valid), 0);
    rd_slot(2, p, l); check("R1", "ep1 out ptr", 32'(p), 170); check("R1", "ep1 out len", 32'(l), 0);
    rd_slot(4, p, l); check("R1", "ep2 out ptr", 32'(p), 340);
    rd_slot(1, p, l); check("R1", "ep0 in ptr", 32'(p), 0);
    // R4 unarmed slot
    token(0, 1, C_NAK, 0, "R4"); cyc(3);
    // R5 IN transfer of four bytes from ep1
    for (int i = 0; i < 4; i++) obuf_wr(16 + i, 8'hA0 + i);
    in_set(1, 16, 4); arm_set(6'b001000);
    check("R2", "arm bit 3 is ep1 IN", 32'(arm_mask), 32'h8);
    for (int i = 0; i < 4; i++) exp_tx(8'hA0 + i, i == 3);
    token(1, 1, C_ACK, 0, "R3"); cyc(10);
    check("R7", "pend after IN", 32'(pend_mask), 32'h8);
    check("R7", "arm after IN", 32'(arm_mask), 0);
    check("R7", "tog after IN", 32'(tog_mask), 32'h8);
    rd_slot(3, p, l); check("R7", "IN ptr", 32'(p), 20); check("R7", "IN len", 32'(l), 0);
    // R4 pending beats arm
    token(1, 1, C_NAK, 1, "R4"); cyc(3);
    arm_set(6'b001000); check("R9", "rearm", 32'(arm_mask), 32'h8);
    token(1, 1, C_NAK, 1, "R4"); cyc(3);
    // R9 pending clear, then zero-length IN
    pend_clr(6'b001000); check("R9", "pend cleared", 32'(pend_mask), 0);
    token(1, 1, C_ACK, 1, "R5"); cyc(6);
    check("R5", "zero length pend", 32'(pend_mask), 32'h8);
    check("R7", "zero length tog", 32'(tog_mask), 0);
    // R6 OUT transfer on ep0
    arm_set(6'b000001);
    token(0, 0, C_ACK, 0, "R3");
    rx_byte(8'h11); rx_byte(8'h22); rx_byte(8'h33); rx_close; cyc(4);
    rd_ibuf(0, v); check("R6", "ibuf0", 32'(v), 32'h11);
    rd_ibuf(1, v); check("R6", "ibuf1", 32'(v), 32'h22);
    rd_ibuf(2, v); check("R11", "ibuf2", 32'(v), 32'h33);
    rd_slot(0, p, l); check("R7", "OUT ptr", 32'(p), 3); check("R7", "OUT len", 32'(l), 3);
    check("R7", "pend after OUT", 32'(pend_mask), 32'h9);
    check("R7", "tog after OUT", 32'(tog_mask), 32'h1);
    // R8 refused OUT writes nothing
    token(0, 0, C_NAK, 1, "R8"); rx_byte(8'h99); rx_close; cyc(4);
    rd_ibuf(3, v); check("R8", "ibuf3 untouched", 32'(v), 0);
    rd_slot(0, p, l); check("R8", "OUT ptr kept", 32'(p), 3); check("R8", "OUT len kept", 32'(l), 3);
    // R4 stall priority
    stall_wr(6'b000011); arm_set(6'b000010);
    check("R9", "stall mask", 32'(stall_mask), 32'h3);
    token(0, 1, C_STALL, 0, "R4"); cyc(3);
    token(0, 0, C_STALL, 1, "R4"); cyc(3);
    check("R8", "stall keeps arm", 32'(arm_mask), 32'h2);
    stall_wr(6'b000000); token(0, 0, C_NAK, 1, "R4"); cyc(3);
    // R9 toggle write, then zero-length IN on ep0
    tog_wr(6'b000010); check("R9", "tog mask", 32'(tog_mask), 32'h2);
    token(0, 1, C_ACK, 1, "R3"); cyc(6);
    check("R7", "tog flipped", 32'(tog_mask), 0);
    check("R7", "pend ep0 in", 32'(pend_mask), 32'hB);
    // R10 out-of-range endpoint
    token(3, 0, C_NAK, 0, "R10"); cyc(3);
    check("R10", "pend unchanged", 32'(pend_mask), 32'hB);
    check("R10", "arm unchanged", 32'(arm_mask), 0);
    // R5 address wrap on ep2 IN
    obuf_wr(510, 8'h5A); obuf_wr(511, 8'h5B); obuf_wr(0, 8'h5C);
    in_set(2, 510, 3); arm_set(6'b100000);
    exp_tx(8'h5A, 0); exp_tx(8'h5B, 0); exp_tx(8'h5C, 1);
    token(2, 1, C_ACK, 0, "R5"); cyc(10);
    rd_slot(5, p, l); check("R5", "wrapped ptr", 32'(p), 1); check("R7", "len zero", 32'(l), 0);
    cyc(4);
    check("R3", "responses left", 32'(q_code.size()), 0);
    check("R5", "tx bytes left", 32'(q_txd.size()), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule